// File: doc/BRIEF.md
# Bucketed Receive Station

This block is the receiving end of one station on a message ring with credit-based flow control. One shared store of 256 message slots is divided into up to eight buckets. Software sets each bucket's size through a small configuration port. A bucket takes a region of the store that starts right after the buckets numbered below it, and it runs as its own circular queue inside that region.

Each message arriving from the ring carries a 7-bit global bucket address, a sender identifier and a payload. The upper four address bits name a station and the lower three name a bucket within it. The station keeps only messages whose station field equals its `STATION_ID` parameter. A local consumer pops one message at a time from a bucket it selects. The payload comes out one cycle later. In that same cycle a single credit pulse, tagged with the sender that wrote the message, goes back toward the ring.

Configuration is checked all the time. A nonzero size must be a power of two, a bucket's start must be a multiple of its size, and the sizes together must fit in the store. A message that arrives at a full or zero-size bucket is a credit-budget error. It is dropped and recorded in a sticky flag.

Top module: `bucket_rx_station`

## Requirements
- R1: After reset every bucket is empty and has size 0, `bktNonEmpty`, `overflow`, `cfgError`, `rspValid` and `creditPulse` are all 0.
- R2: A message whose address bits [6:3] differ from `STATION_ID` is ignored. No bucket changes and no flag is set.
- R3: Messages popped from one bucket come out in arrival order. `rspData` and `creditSrc` are valid in the cycle after the pop cycle and carry the payload and the sender of that message.
- R4: Each pop of a nonempty bucket produces exactly one `creditPulse`, one cycle wide, together with `rspValid`. A pop of an empty bucket produces neither.
- R5: A bucket of size 0 accepts no message. A message addressed to it is dropped and sets `overflow`.
- R6: A message addressed to a full bucket is dropped and sets `overflow`. The flag stays at 1 until reset, and the bucket's stored messages are unchanged.
- R7: A bucket's region starts at the sum of the sizes of all lower-numbered buckets. Read and write positions wrap inside that region, so buckets never corrupt one another.
- R8: `cfgError` is 1, from the cycle after the offending write, while any nonzero size is not a power of two, any nonzero-size bucket starts at an offset that is not a multiple of its size, or the sizes sum to more than 256.
- R9: A configuration write to a bucket empties that bucket.
- R10: A push and a pop on the same nonempty bucket in one cycle both take effect. The pop returns the older message and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Bucket whose size is written |
| cfgSize | input | 9 | New bucket size in slots (0 to 256) |
| msgValid | input | 1 | Incoming message valid |
| msgBucket | input | 7 | Global bucket address: [6:3] station, [2:0] local bucket |
| msgSrc | input | 5 | Sender identifier of the incoming message |
| msgData | input | 32 | Message payload |
| popValid | input | 1 | Consumer pop request |
| popBucket | input | 3 | Local bucket to pop |
| rspValid | output | 1 | Popped payload valid |
| rspData | output | 32 | Popped payload |
| creditPulse | output | 1 | One credit returned to a sender |
| creditSrc | output | 5 | Sender receiving the credit |
| bktNonEmpty | output | 8 | One bit per bucket, 1 while the bucket holds a message |
| overflow | output | 1 | Sticky dropped-message flag |
| cfgError | output | 1 | Current configuration is illegal |

## Verification
A wrong region start or a pointer that wraps wrongly puts one bucket's slots inside another's. That shows up at `rspData` as a payload from the wrong bucket or out of order, and only when the corrupted slot is popped. The bench therefore fills neighbouring buckets, loops their pointers several times, and compares every response against a model queue kept for each bucket. A wrong fill count shows up at `bktNonEmpty`, at `overflow`, or as a missing or extra credit one cycle after a pop. Configuration faults show up at `cfgError` one cycle after the write.

// File: rtl/bucket_rx_pkg.sv
package bucket_rx_pkg;
  localparam int STORE_DEPTH = 256;
  localparam int NUM_BKT     = 8;
  localparam int BKT_W       = $clog2(NUM_BKT);
  localparam int STN_W       = 4;
  localparam int ADDR_W      = STN_W + BKT_W;
  localparam int PTR_W       = $clog2(STORE_DEPTH);
  localparam int SZ_W        = PTR_W + 1;
  localparam int SUM_W       = SZ_W + BKT_W;

  typedef struct packed {
    logic             push;
    logic [BKT_W-1:0] pushBkt;
    logic             pop;
    logic [BKT_W-1:0] popBkt;
    logic             clr;
    logic [BKT_W-1:0] clrBkt;
  } stn_strobe_t;
endpackage

// File: rtl/bucket_rx_ctrl.sv
module bucket_rx_ctrl
  import bucket_rx_pkg::*;
#(
  parameter logic [STN_W-1:0] STATION_ID = 4'd5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cfgWe,
  input  logic [BKT_W-1:0]                 cfgSel,
  input  logic [SZ_W-1:0]                  cfgSize,
  input  logic                             msgValid,
  input  logic [ADDR_W-1:0]                msgBucket,
  input  logic                             popValid,
  input  logic [BKT_W-1:0]                 popBucket,
  input  logic [NUM_BKT-1:0][SZ_W-1:0]     bktCount,
  output stn_strobe_t                      strobe,
  output logic [NUM_BKT-1:0][SZ_W-1:0]     bktSize,
  output logic [NUM_BKT-1:0][PTR_W-1:0]    bktStart,
  output logic                             overflow,
  output logic                             cfgError
);
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] sizeExt;
  logic             stnHit;
  logic [BKT_W-1:0] dstBkt;
  logic             dstFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bktSize <= '0;
    end else if (cfgWe) begin
      bktSize[cfgSel] <= cfgSize;
    end
  end

  // region layout and legality check
  always_comb begin
    acc      = '0;
    cfgError = 1'b0;
    sizeExt  = '0;
    for (int i = 0; i < NUM_BKT; i++) begin
      bktStart[i] = acc[PTR_W-1:0];
      sizeExt     = SUM_W'(bktSize[i]);
      if (bktSize[i] != '0) begin
        if ((bktSize[i] & (bktSize[i] - 1'b1)) != '0) cfgError = 1'b1;
        if ((acc & (sizeExt - 1'b1)) != '0)           cfgError = 1'b1;
      end
      acc = acc + sizeExt;
    end
    if (acc > SUM_W'(STORE_DEPTH)) cfgError = 1'b1;
  end

  assign stnHit  = msgValid && (msgBucket[ADDR_W-1:BKT_W] == STATION_ID);
  assign dstBkt  = msgBucket[BKT_W-1:0];
  assign dstFull = (bktCount[dstBkt] == bktSize[dstBkt]);

  always_comb begin
    strobe         = '0;
    strobe.push    = stnHit && !dstFull;
    strobe.pushBkt = dstBkt;
    strobe.pop     = popValid && (bktCount[popBucket] != '0);
    strobe.popBkt  = popBucket;
    strobe.clr     = cfgWe;
    strobe.clrBkt  = cfgSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else if (stnHit && dstFull) overflow <= 1'b1;
  end
endmodule

// File: rtl/bucket_rx_datapath.sv
module bucket_rx_datapath
  import bucket_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SRC_W  = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  stn_strobe_t                    strobe,
  input  logic [NUM_BKT-1:0][SZ_W-1:0]   bktSize,
  input  logic [NUM_BKT-1:0][PTR_W-1:0]  bktStart,
  input  logic [SRC_W-1:0]               msgSrc,
  input  logic [DATA_W-1:0]              msgData,
  output logic [NUM_BKT-1:0][SZ_W-1:0]   bktCount,
  output logic                           rspValid,
  output logic [DATA_W-1:0]              rspData,
  output logic [SRC_W-1:0]               rspSrc
);
  localparam int ENTRY_W = DATA_W + SRC_W;

  logic [ENTRY_W-1:0] store [STORE_DEPTH];
  logic [NUM_BKT-1:0][PTR_W-1:0] wrPtr;
  logic [NUM_BKT-1:0][PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrAddr;
  logic [PTR_W-1:0] rdAddr;

  for (genvar g = 0; g < NUM_BKT; g++) begin : g_bkt
    logic pushHit;
    logic popHit;
    assign pushHit = strobe.push && (strobe.pushBkt == BKT_W'(g));
    assign popHit  = strobe.pop  && (strobe.popBkt  == BKT_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN || (strobe.clr && strobe.clrBkt == BKT_W'(g))) begin
        wrPtr[g]    <= '0;
        rdPtr[g]    <= '0;
        bktCount[g] <= '0;
      end else begin
        if (pushHit)
          wrPtr[g] <= ({1'b0, wrPtr[g]} == bktSize[g] - 1'b1) ? '0 : wrPtr[g] + 1'b1;
        if (popHit)
          rdPtr[g] <= ({1'b0, rdPtr[g]} == bktSize[g] - 1'b1) ? '0 : rdPtr[g] + 1'b1;
        bktCount[g] <= bktCount[g] + SZ_W'(pushHit) - SZ_W'(popHit);
      end
    end
  end

  assign wrAddr = bktStart[strobe.pushBkt] + wrPtr[strobe.pushBkt];
  assign rdAddr = bktStart[strobe.popBkt]  + rdPtr[strobe.popBkt];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrAddr] <= {msgSrc, msgData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspSrc   <= '0;
    end else begin
      rspValid <= strobe.pop;
      if (strobe.pop) {rspSrc, rspData} <= store[rdAddr];
    end
  end
endmodule

// File: rtl/bucket_rx_station.sv
module bucket_rx_station
  import bucket_rx_pkg::*;
#(
  parameter logic [3:0] STATION_ID = 4'd5,
  parameter int         DATA_W     = 32,
  parameter int         SRC_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [8:0]        cfgSize,
  input  logic              msgValid,
  input  logic [6:0]        msgBucket,
  input  logic [SRC_W-1:0]  msgSrc,
  input  logic [DATA_W-1:0] msgData,
  input  logic              popValid,
  input  logic [2:0]        popBucket,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              creditPulse,
  output logic [SRC_W-1:0]  creditSrc,
  output logic [7:0]        bktNonEmpty,
  output logic              overflow,
  output logic              cfgError
);
  stn_strobe_t                   strobe;
  logic [NUM_BKT-1:0][SZ_W-1:0]  bktSize;
  logic [NUM_BKT-1:0][SZ_W-1:0]  bktCount;
  logic [NUM_BKT-1:0][PTR_W-1:0] bktStart;

  bucket_rx_ctrl #(.STATION_ID(STATION_ID)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgSize(cfgSize),
    .msgValid(msgValid), .msgBucket(msgBucket), .popValid(popValid),
    .popBucket(popBucket), .bktCount(bktCount), .strobe(strobe),
    .bktSize(bktSize), .bktStart(bktStart), .overflow(overflow),
    .cfgError(cfgError)
  );

  bucket_rx_datapath #(.DATA_W(DATA_W), .SRC_W(SRC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bktSize(bktSize),
    .bktStart(bktStart), .msgSrc(msgSrc), .msgData(msgData),
    .bktCount(bktCount), .rspValid(rspValid), .rspData(rspData),
    .rspSrc(creditSrc)
  );

  assign creditPulse = rspValid;

  for (genvar g = 0; g < NUM_BKT; g++) begin : g_ne
    assign bktNonEmpty[g] = (bktCount[g] != '0);
  end
endmodule

// File: rtl/bucket_rx_checker.sv
module bucket_rx_checker #(
  parameter logic [3:0] STATION_ID = 4'd5
) (
  input logic       clk,
  input logic       rstN,
  input logic       msgValid,
  input logic [6:0] msgBucket,
  input logic       popValid,
  input logic [2:0] popBucket,
  input logic [7:0] bktNonEmpty,
  input logic       rspValid,
  input logic       creditPulse,
  input logic       overflow
);
  AST_CREDIT_ON_POP: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && bktNonEmpty[popBucket]) |=> creditPulse); // R4
  AST_NO_CREDIT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (!popValid || !bktNonEmpty[popBucket]) |=> !creditPulse); // R4
  AST_RSP_NEEDS_POP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(popValid)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(msgValid && msgBucket[6:3] == STATION_ID)); // R2
endmodule

bind bucket_rx_station bucket_rx_checker #(.STATION_ID(STATION_ID)) i_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgBucket(msgBucket),
  .popValid(popValid), .popBucket(popBucket), .bktNonEmpty(bktNonEmpty),
  .rspValid(rspValid), .creditPulse(creditPulse), .overflow(overflow)
);

// File: tb/test_bucket_rx_station.sv
`timescale 1ns/1ps
module test_bucket_rx_station;
  localparam logic [3:0] STN = 4'd5;
  localparam int DW = 32;
  localparam int SW = 5;

  logic clk = 0;
  logic rstN = 0;
  logic cfgWe = 0;
  logic [2:0] cfgSel = 0;
  logic [8:0] cfgSize = 0;
  logic msgValid = 0;
  logic [6:0] msgBucket = 0;
  logic [SW-1:0] msgSrc = 0;
  logic [DW-1:0] msgData = 0;
  logic popValid = 0;
  logic [2:0] popBucket = 0;
  logic rspValid, creditPulse, overflow, cfgError;
  logic [DW-1:0] rspData;
  logic [SW-1:0] creditSrc;
  logic [7:0] bktNonEmpty;

  bucket_rx_station #(.STATION_ID(STN)) i_bucket_rx_station (.*);

  always #10 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;
  logic [DW+SW-1:0] mdl [8][$];
  logic [DW+SW-1:0] expQ [$];
  int cfgSz [8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares every response and credit against the scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(creditPulse == rspValid, "R4 credit with response", creditPulse, rspValid);
      if (rspValid) begin
        if (expQ.size() == 0) chk(0, "R4 unexpected response", rspData, 0);
        else begin
          logic [DW+SW-1:0] e;
          e = expQ.pop_front();
          chk({creditSrc, rspData} == e, "R3 payload and sender", {creditSrc, rspData}, e);
        end
      end
    end
  end

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin mdl[i].delete(); cfgSz[i] = 0; end
    rstN = 1;
  endtask

  task automatic cfg(input int sel, input int sz);
    cfgWe = 1; cfgSel = 3'(sel); cfgSize = 9'(sz);
    mdl[sel].delete(); cfgSz[sel] = sz;
    @(posedge clk); @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic step(input bit doPush, input logic [6:0] adr, input logic [SW-1:0] src,
                      input logic [DW-1:0] dat, input bit doPop, input logic [2:0] pb);
    int b;
    bit full;
    b = adr[2:0];
    full = mdl[b].size() >= cfgSz[b];
    msgValid = doPush; msgBucket = adr; msgSrc = src; msgData = dat;
    popValid = doPop; popBucket = pb;
    if (doPop && mdl[pb].size() > 0) expQ.push_back(mdl[pb].pop_front());
    if (doPush && adr[6:3] == STN && !full) mdl[b].push_back({src, dat});
    @(posedge clk); @(negedge clk);
    msgValid = 0; popValid = 0;
  endtask

  function automatic logic [6:0] ad(input logic [3:0] s, input int b);
    return {s, 3'(b)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    chk(bktNonEmpty == 0, "R1 empty", bktNonEmpty, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(cfgError == 0, "R1 cfgError", cfgError, 0);
    chk(rspValid == 0 && creditPulse == 0, "R1 outputs", rspValid, 0);

    cfg(0, 32); cfg(1, 32); cfg(2, 64); cfg(3, 128);
    chk(cfgError == 0, "R8 legal layout", cfgError, 0);

    step(1, ad(4'd3, 0), 5'd1, 32'hDEAD0001, 0, 0);
    step(1, ad(4'd6, 2), 5'd1, 32'hDEAD0002, 0, 0);
    chk(bktNonEmpty == 0, "R2 foreign station ignored", bktNonEmpty, 0);
    chk(overflow == 0, "R2 no flag", overflow, 0);

    for (int i = 0; i < 6; i++) begin
      step(1, ad(STN, 0), 5'(i), 32'h1000 + i, 0, 0);
      step(1, ad(STN, 2), 5'(i + 8), 32'h2000 + i, 0, 0);
      step(1, ad(STN, 3), 5'(i + 16), 32'h3000 + i, 0, 0);
    end
    chk(bktNonEmpty == 8'b0000_1101, "R7 occupancy", bktNonEmpty, 8'b0000_1101);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 0, 1, 3'd3);
      step(0, 0, 0, 0, 1, 3'd0);
      step(0, 0, 0, 0, 1, 3'd2);
    end
    step(0, 0, 0, 0, 1, 3'd1);
    chk(creditPulse == 0, "R4 empty pop no credit", creditPulse, 0);
    chk(bktNonEmpty == 0, "R3 drained", bktNonEmpty, 0);

    step(1, ad(STN, 5), 5'd2, 32'h5555, 0, 0);
    chk(overflow == 1, "R5 zero-size drop", overflow, 1);
    chk(bktNonEmpty[5] == 0, "R5 zero-size empty", bktNonEmpty[5], 0);
    repeat (3) step(0, 0, 0, 0, 0, 0);
    chk(overflow == 1, "R6 sticky", overflow, 1);

    doReset();
    cfg(0, 4); cfg(1, 4);
    for (int i = 0; i < 5; i++) step(1, ad(STN, 0), 5'd3, 32'hA0 + i, 0, 0);
    chk(overflow == 1, "R6 full drop", overflow, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 3'd0);
    chk(bktNonEmpty[0] == 0, "R6 four kept", bktNonEmpty[0], 0);

    for (int i = 0; i < 3; i++) step(1, ad(STN, 0), 5'd4, 32'hB0 + i, 0, 0);
    for (int i = 0; i < 2; i++) step(1, ad(STN, 1), 5'd5, 32'hC0 + i, 0, 0);
    for (int i = 0; i < 10; i++) begin
      step(1, ad(STN, 0), 5'd6, 32'hD0 + i, 1, 3'd0);
      step(1, ad(STN, 1), 5'd7, 32'hE0 + i, 1, 3'd1);
    end
    chk(bktNonEmpty[1:0] == 2'b11, "R10 level kept", bktNonEmpty[1:0], 2'b11);
    repeat (4) step(0, 0, 0, 0, 1, 3'd0);
    repeat (3) step(0, 0, 0, 0, 1, 3'd1);
    chk(bktNonEmpty == 0, "R7 wrap drained", bktNonEmpty, 0);

    step(1, ad(STN, 1), 5'd8, 32'hF0, 0, 0);
    cfg(1, 4);
    chk(bktNonEmpty[1] == 0, "R9 cfg clears", bktNonEmpty[1], 0);
    step(0, 0, 0, 0, 1, 3'd1);

    cfg(2, 3);
    chk(cfgError == 1, "R8 non power of two", cfgError, 1);
    cfg(2, 16);
    chk(cfgError == 1, "R8 misaligned start", cfgError, 1);
    cfg(2, 8); cfg(3, 256);
    chk(cfgError == 1, "R8 total too large", cfgError, 1);
    cfg(3, 0);
    chk(cfgError == 0, "R8 legal again", cfgError, 0);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R4 all responses seen", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule